// File: doc/BRIEF.md
# Prefetch Destination Splitter

This block chooses where the input data of the task that will run next is placed when a block prefetch is issued. Every block request (a base address and a byte length) is split between the private second-level cache and the shared last-level cache. The split depends on how much room the private cache still has. That room is estimated from the configured second-level capacity, minus the input size of the task now running, minus the bytes already sent to the second level for the next task.

A request yields at most two commands in the cycle after it is accepted. The second-level portion always comes first and covers the lower addresses. The last-level portion covers the remainder. A single level bit in each command names its target. A pulse on `task_start` marks the start of a new next-task window and clears the running byte count. For the very first task the caches are treated as holding stale data, so the running task's size is ignored. When no shared level is present, the part that would go there is dropped.

Top module: `pf_dest_split`

## Requirements
- R1: After reset both command slots are invalid and the count of bytes sent to the second level is zero.
- R2: The second-level room is `cfg_l2_bytes - run_bytes - sent`, where `sent` is the sum of second-level bytes emitted since the last `task_start`. The portion sent to the second level is `min(req_len, room)`.
- R3: When that difference is negative, the room is clamped to zero and the whole request goes to the shared level.
- R4: The second-level portion is emitted first in slot A, starting at `req_addr`. Any remainder is emitted in slot B at `req_addr` plus the slot A length. No request produces more than two commands.
- R5: The level bit is 0 for the private second-level cache and 1 for the shared last-level cache. No other destination exists.
- R6: When `cfg_l3_present` is 0, the shared-level portion is dropped and only the second-level portion, if any, is emitted.
- R7: While `first_task` is 1, `run_bytes` is treated as zero.
- R8: A request with `req_len` of 0 emits no command and leaves the count unchanged.
- R9: `task_start` clears the count. A request in the same cycle sees the cleared count.
- R10: Commands appear exactly one cycle after `req_valid` and stay valid for that single cycle only.
- R11: The count grows only by the second-level bytes emitted. Bytes sent to the shared level and dropped bytes do not add to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_l2_bytes | input | SW | Private second-level capacity in bytes |
| cfg_l3_present | input | 1 | Shared level exists and may be targeted |
| run_bytes | input | SW | Input size of the running task |
| first_task | input | 1 | Running task is the first, so its size is ignored |
| task_start | input | 1 | Clears the next-task byte count |
| req_valid | input | 1 | Block request strobe |
| req_addr | input | AW | Block base address |
| req_len | input | SW | Block length in bytes |
| a_valid | output | 1 | Slot A command valid |
| a_lvl | output | 1 | Slot A level bit (0 = second level, 1 = shared) |
| a_addr | output | AW | Slot A address |
| a_len | output | SW | Slot A length |
| b_valid | output | 1 | Slot B command valid |
| b_lvl | output | 1 | Slot B level bit |
| b_addr | output | AW | Slot B address |
| b_len | output | SW | Slot B length |

## Verification
The hardest condition to reach is a negative room estimate. It needs the running task's input plus the bytes already prefetched to exceed the capacity, without a `task_start` clearing the count in between. The random stimulus keeps capacities small relative to the lengths and issues several requests per window to get there. Directed cases also cover a running size larger than the capacity, a request that exactly fills the room, and a `task_start` that lands in the same cycle as a request.

// File: rtl/pf_dest_split.sv
module pf_dest_split #(
  parameter int AW = 32,
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cfg_l2_bytes,
  input  logic          cfg_l3_present,
  input  logic [SW-1:0] run_bytes,
  input  logic          first_task,
  input  logic          task_start,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_len,
  output logic          a_valid,
  output logic          a_lvl,
  output logic [AW-1:0] a_addr,
  output logic [SW-1:0] a_len,
  output logic          b_valid,
  output logic          b_lvl,
  output logic [AW-1:0] b_addr,
  output logic [SW-1:0] b_len
);
  localparam int DW = SW + 2;

  logic [SW-1:0] sent_q;
  logic [SW-1:0] sent_eff, run_eff, room, l2_part, l3_part;
  logic [DW-1:0] diff;
  logic          has_l2, has_l3;

  assign sent_eff = task_start ? '0 : sent_q;
  assign run_eff  = first_task ? '0 : run_bytes;
  assign diff     = {2'b00, cfg_l2_bytes} - {2'b00, run_eff} - {2'b00, sent_eff};
  assign room     = diff[DW-1] ? '0 : diff[SW-1:0];
  assign l2_part  = (req_len < room) ? req_len : room;
  assign l3_part  = req_len - l2_part;
  assign has_l2   = l2_part != '0;
  assign has_l3   = (l3_part != '0) && cfg_l3_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_q  <= '0;
      a_valid <= 1'b0;
      a_lvl   <= 1'b0;
      a_addr  <= '0;
      a_len   <= '0;
      b_valid <= 1'b0;
      b_lvl   <= 1'b0;
      b_addr  <= '0;
      b_len   <= '0;
    end else begin
      sent_q  <= (req_valid ? sent_eff + l2_part : sent_eff);
      a_valid <= req_valid && (has_l2 || has_l3);
      a_lvl   <= !has_l2;
      a_addr  <= req_addr;
      a_len   <= has_l2 ? l2_part : l3_part;
      b_valid <= req_valid && has_l2 && has_l3;
      b_lvl   <= 1'b1;
      b_addr  <= req_addr + AW'(l2_part);
      b_len   <= l3_part;
    end
  end
endmodule

// File: rtl/pf_dest_split_chk.sv
module pf_dest_split_chk #(
  parameter int AW = 32,
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_l3_present,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [SW-1:0] req_len,
  input logic          a_valid,
  input logic          a_lvl,
  input logic [AW-1:0] a_addr,
  input logic [SW-1:0] a_len,
  input logic          b_valid,
  input logic          b_lvl,
  input logic [AW-1:0] b_addr,
  input logic [SW-1:0] b_len
);
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (a_valid && !a_lvl && b_lvl));
  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (b_addr == a_addr + AW'(a_len)));
  p_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_addr == $past(req_addr)));
  p_no_l3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_l3_present) |-> (!b_valid && !(a_valid && a_lvl)));
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_len == '0) |-> (!a_valid && !b_valid));
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!a_valid && !b_valid));
  p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && cfg_l3_present) |->
      ({1'b0, (a_valid ? a_len : '0)} + {1'b0, (b_valid ? b_len : '0)}) == {1'b0, $past(req_len)});
endmodule

bind pf_dest_split pf_dest_split_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_l3_present(cfg_l3_present),
  .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
  .a_valid(a_valid), .a_lvl(a_lvl), .a_addr(a_addr), .a_len(a_len),
  .b_valid(b_valid), .b_lvl(b_lvl), .b_addr(b_addr), .b_len(b_len)
);

// File: tb/pf_dest_split_bench.sv
`timescale 1ns/1ps
module pf_dest_split_bench;
  localparam int AW = 32;
  localparam int SW = 24;
  localparam int KB = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] cfg_l2_bytes = '0;
  logic cfg_l3_present = 1'b1;
  logic [SW-1:0] run_bytes = '0;
  logic first_task = 1'b0, task_start = 1'b0, req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_len = '0;
  logic a_valid, a_lvl, b_valid, b_lvl;
  logic [AW-1:0] a_addr, b_addr;
  logic [SW-1:0] a_len, b_len;

  int tests = 0, fails = 0;
  longint m_sent = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pf_dest_split #(.AW(AW), .SW(SW)) u_pf_dest_split (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at the following negedge
  task automatic issue(input longint l2, input longint run, input bit first, input bit ts,
                       input bit l3, input longint addr, input longint len, input string tag);
    longint room, p2, p3;
    bit e_a, e_b, e_alvl;
    longint e_alen;
    if (ts) m_sent = 0;
    room = l2 - (first ? 0 : run) - m_sent;
    if (room < 0) room = 0;                 // R3
    p2 = (len < room) ? len : room;
    p3 = len - p2;
    e_a = (p2 != 0) || (p3 != 0 && l3);
    e_b = (p2 != 0) && (p3 != 0 && l3);
    e_alvl = (p2 == 0);
    e_alen = (p2 != 0) ? p2 : p3;
    m_sent += p2;                           // R11
    cfg_l2_bytes = SW'(l2); run_bytes = SW'(run); first_task = first;
    task_start = ts; cfg_l3_present = l3; req_valid = 1'b1;
    req_addr = AW'(addr); req_len = SW'(len);
    @(negedge clk);
    req_valid = 1'b0; task_start = 1'b0;
    chk({tag, " R10 a_valid"}, a_valid, e_a);
    chk({tag, " R6/R8 b_valid"}, b_valid, e_b);
    if (e_a) begin
      chk({tag, " R5 a_lvl"}, a_lvl, e_alvl);
      chk({tag, " R2 a_len"}, a_len, e_alen);
      chk({tag, " R4 a_addr"}, a_addr, addr & 64'hFFFF_FFFF);
    end
    if (e_b) begin
      chk({tag, " R5 b_lvl"}, b_lvl, 1);
      chk({tag, " R4 b_len"}, b_len, p3);
      chk({tag, " R4 b_addr"}, b_addr, (addr + p2) & 64'hFFFF_FFFF);
    end
    @(negedge clk);
    chk({tag, " R10 single cycle"}, a_valid | b_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset a_valid", a_valid, 0);
    chk("R1 reset b_valid", b_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", a_valid | b_valid, 0);

    // R7: first task, 128K L2, 160K input -> 128K / 32K
    issue(128*KB, 999*KB, 1, 1, 1, 32'h1000_0000, 160*KB, "R7 first");
    // R2: 256K L2, 160K running, 160K next -> 96K / 64K, in two requests
    issue(256*KB, 160*KB, 0, 1, 1, 32'h2000_0000, 40*KB, "R2 part1");
    issue(256*KB, 160*KB, 0, 0, 1, 32'h2000_A000, 120*KB, "R2 part2");
    // R11: room now zero, whole request goes to shared level
    issue(256*KB, 160*KB, 0, 0, 1, 32'h3000_0000, 8*KB, "R11 full");
    // R3: running larger than L2
    issue(64*KB, 100*KB, 0, 1, 1, 32'h4000_0000, 16*KB, "R3 clamp");
    // R8: zero length
    issue(64*KB, 0, 0, 1, 1, 32'h5000_0000, 0, "R8 zero");
    issue(64*KB, 0, 0, 0, 1, 32'h5000_0000, 64*KB, "R8 count kept");
    // R6: no shared level
    issue(32*KB, 0, 0, 1, 0, 32'h6000_0000, 48*KB, "R6 drop");
    issue(32*KB, 0, 0, 0, 0, 32'h6000_0000, 4*KB, "R6 all dropped");
    // R9: task_start with request sees cleared count
    issue(32*KB, 0, 0, 1, 1, 32'h7000_0000, 20*KB, "R9 clear");

    for (int i = 0; i < 400; i++) begin
      longint l2 = longint'($urandom_range(1, 64)) * 256;
      longint run = longint'($urandom_range(0, 80)) * 256;
      longint len = ($urandom_range(0, 9) == 0) ? 0 : longint'($urandom_range(1, 40)) * 100;
      issue(l2, run, $urandom_range(0, 7) == 0, $urandom_range(0, 4) == 0,
            $urandom_range(0, 5) != 0, longint'($urandom), len, "R4 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule